// File: doc/BRIEF.md
# Gated 22 kHz Tone Generator

This block divides the system clock down to a 22 kHz square wave for one output section. The wave is then gated by three control bits and a TTL keying input. An enable bit powers the section. An arm bit, ORed with an arm pin, lets the internal generator run at all. A continuous bit keeps the tone running without keying. When the block is armed and the continuous bit is clear, the keying input carries burst signalling: the tone starts half a tone cycle after the key rises, and it keeps running for one extra tone cycle after the key falls.

Besides the tone, the block drives a sink flag and an external-modulation select. The sink flag is high for the whole of each tone run and drives an external active pull-down. The external-modulation select goes high when the section is enabled and the internal generator is neither armed nor in continuous mode. Every run begins with a high half and ends after a complete low half, so no shortened pulse ever reaches the output. The keying input and the arm pin are asynchronous and pass through two-flop synchronizers.

Top module: `tone22k_gate`

## Requirements
- R1: While `rst_n` is low, and after its release until stimulus arrives, `tone_o`, `sink_o` and `ext_mod_o` are all 0.
- R2: Within a run, each high half and each low half of `tone_o` lasts HALF = round(CLK_HZ / (2·TONE_HZ)) clock cycles. HALF is 20 at 880 kHz / 22 kHz, giving a period P = 2·HALF.
- R3: With `en_i`=1, arm=1 and `cont_i`=1, `tone_o` and `sink_o` go high at the first clock edge that samples these values.
- R4: With `en_i`=1, arm=1 and `cont_i`=0, a rising `key_i` makes `tone_o` first high HALF+2 edges after the first edge that samples `key_i` high. This is two synchronizer stages plus half a tone cycle.
- R5: A run continues while the hold condition, arm AND (`cont_i` OR synchronized key), is true. Let j be the number of edges from the run's first edge to the first edge that sees the condition false. The run then produces exactly max(1, ceil(j/P)) + 1 high pulses, ends after a full low half, and leaves `tone_o` at 0.
- R6: arm is `arm_bit_i` OR the synchronized `arm_pin_i`. While arm is 0, neither `key_i` nor `cont_i` produces any tone, and `sink_o` stays 0. The arm pin alone arms the block with the same burst timing as the arm bit.
- R7: `ext_mod_o` is 1 from the edge after `en_i`=1, arm=0 and `cont_i`=0 are sampled. It is 0 in every other case.
- R8: `en_i`=0 forces `tone_o`, `sink_o` and `ext_mod_o` to 0 at the next clock edge, even in the middle of a high half.
- R9: `sink_o` is high for exactly (pulses)·P cycles per run, rising together with the first high half. `tone_o` is never high while `sink_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Section enable bit |
| arm_bit_i | input | 1 | Arm bit from the control register |
| arm_pin_i | input | 1 | Asynchronous arm pin, ORed with the arm bit |
| cont_i | input | 1 | Continuous tone bit |
| key_i | input | 1 | Asynchronous TTL keying input for bursts |
| tone_o | output | 1 | Gated 22 kHz square wave |
| sink_o | output | 1 | High while the internal tone runs (pull-down control) |
| ext_mod_o | output | 1 | Selects external analog modulation |

## Verification
The bench targets the stop rule at the cycle boundary. It uses keying lengths whose release lands exactly on a boundary, and one edge past it. A design that rounded the wrong way there would emit one pulse too few or too many. Keying shorter than the start delay must still yield two full pulses; a design that dropped the run while waiting would emit nothing. Disabling in the middle of a high half must clear the output at once, and keying while unarmed must leave the output and the sink flag silent. A generator that leaked through would show pulses with no expected run queued.

// File: rtl/tone22k_pkg.sv
package tone22k_pkg;

    typedef enum logic [1:0] {
        TG_IDLE = 2'd0,
        TG_WAIT = 2'd1,
        TG_RUN  = 2'd2
    } tg_state_e;

    typedef struct packed {
        tg_state_e st;
        logic      hi;
        logic      pend;
        logic      tail;
        logic      ext;
    } tg_regs_t;

    function automatic int half_cycles(input int clk_hz, input int tone_hz);
        return (clk_hz + tone_hz) / (2 * tone_hz);
    endfunction

endpackage

// File: rtl/tone22k_sync.sv
module tone22k_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q, stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/tone22k_phase_ctr.sv
module tone22k_phase_ctr #(
    parameter int HALF = 2273
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    output logic last_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (adv_i) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/tone22k_gate_fsm.sv
module tone22k_gate_fsm
    import tone22k_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic arm_i,
    input  logic cont_i,
    input  logic key_i,
    input  logic last_i,
    output logic clr_o,
    output logic adv_o,
    output logic tone_o,
    output logic sink_o,
    output logic ext_o
);
    tg_regs_t r_q, r_d;
    logic     keep;

    always_comb begin
        r_d    = r_q;
        clr_o  = 1'b0;
        adv_o  = 1'b0;
        keep   = arm_i && (cont_i || key_i);
        r_d.ext = en_i && !arm_i && !cont_i;

        case (r_q.st)
            TG_IDLE: begin
                clr_o    = 1'b1;
                r_d.hi   = 1'b0;
                r_d.pend = 1'b0;
                r_d.tail = 1'b0;
                if (en_i && arm_i) begin
                    if (cont_i) begin
                        r_d.st = TG_RUN;
                        r_d.hi = 1'b1;
                    end else if (key_i) begin
                        r_d.st = TG_WAIT;
                    end
                end
            end
            TG_WAIT: begin
                adv_o = 1'b1;
                if (!en_i || !arm_i) begin
                    r_d.st = TG_IDLE;
                    clr_o  = 1'b1;
                    adv_o  = 1'b0;
                end else if (last_i) begin
                    r_d.st = TG_RUN;
                    r_d.hi = 1'b1;
                end
            end
            TG_RUN: begin
                adv_o = 1'b1;
                if (!en_i) begin
                    r_d.st   = TG_IDLE;
                    r_d.hi   = 1'b0;
                    r_d.pend = 1'b0;
                    r_d.tail = 1'b0;
                    clr_o    = 1'b1;
                    adv_o    = 1'b0;
                end else begin
                    if (!keep) r_d.pend = 1'b1;
                    if (last_i) begin
                        if (r_q.hi) begin
                            r_d.hi = 1'b0;
                        end else if (r_q.tail) begin
                            r_d.st   = TG_IDLE;
                            r_d.pend = 1'b0;
                            r_d.tail = 1'b0;
                        end else begin
                            r_d.hi = 1'b1;
                            if (r_q.pend || !keep) r_d.tail = 1'b1;
                        end
                    end
                end
            end
            default: begin
                r_d.st = TG_IDLE;
                r_d.hi = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: TG_IDLE, hi: 1'b0, pend: 1'b0, tail: 1'b0, ext: 1'b0};
        else        r_q <= r_d;
    end

    assign tone_o = r_q.hi;
    assign sink_o = (r_q.st == TG_RUN);
    assign ext_o  = r_q.ext;
endmodule

// File: rtl/tone22k_gate.sv
module tone22k_gate
    import tone22k_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TONE_HZ = 22_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic arm_bit_i,
    input  logic arm_pin_i,
    input  logic cont_i,
    input  logic key_i,
    output logic tone_o,
    output logic sink_o,
    output logic ext_mod_o
);
    localparam int HALF_CYC = half_cycles(CLK_HZ, TONE_HZ);

    logic [1:0] raw_in, syn_in;
    logic       key_s, arm_pin_s, arm_any;
    logic       ctr_clr, ctr_adv, ctr_last;

    assign raw_in = {arm_pin_i, key_i};

    tone22k_sync #(.W(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    assign key_s     = syn_in[0];
    assign arm_pin_s = syn_in[1];
    assign arm_any   = arm_bit_i | arm_pin_s;

    tone22k_phase_ctr #(.HALF(HALF_CYC)) i_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ctr_clr),
        .adv_i  (ctr_adv),
        .last_o (ctr_last)
    );

    tone22k_gate_fsm i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .arm_i  (arm_any),
        .cont_i (cont_i),
        .key_i  (key_s),
        .last_i (ctr_last),
        .clr_o  (ctr_clr),
        .adv_o  (ctr_adv),
        .tone_o (tone_o),
        .sink_o (sink_o),
        .ext_o  (ext_mod_o)
    );
endmodule

// File: rtl/tone22k_gate_chk.sv
module tone22k_gate_chk
    import tone22k_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TONE_HZ = 22_000
) (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic arm_bit_i,
    input logic cont_i,
    input logic tone_o,
    input logic sink_o,
    input logic ext_mod_o
);
    localparam int HALF = half_cycles(CLK_HZ, TONE_HZ);
    localparam int SW   = $clog2(HALF + 2) + 1;
    localparam logic [SW-1:0] SMAX = '1;

    logic          prev_tone_q, prev_sink_q;
    logic [SW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_tone_q <= 1'b0;
            prev_sink_q <= 1'b0;
            since_q     <= '0;
        end else begin
            prev_tone_q <= tone_o;
            prev_sink_q <= sink_o;
            if (tone_o != prev_tone_q) since_q <= SW'(1);
            else if (since_q != SMAX)  since_q <= since_q + 1'b1;
        end
    end

    p_half_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_o != prev_tone_q && sink_o && prev_sink_q) |-> (since_q == SW'(HALF)));

    p_ext_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mod_o |-> ($past(en_i) && !$past(arm_bit_i) && !$past(cont_i)));

    p_en_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!tone_o && !sink_o && !ext_mod_o));

    p_tone_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tone_o |-> sink_o);

    p_run_starts_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sink_o) |-> tone_o);

    p_ends_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sink_o) && $past(en_i)) |-> !$past(tone_o));
endmodule

bind tone22k_gate tone22k_gate_chk #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .arm_bit_i (arm_bit_i),
    .cont_i    (cont_i),
    .tone_o    (tone_o),
    .sink_o    (sink_o),
    .ext_mod_o (ext_mod_o)
);

// File: tb/test_tone22k_gate.sv
module test_tone22k_gate;
    localparam int CLK_HZ  = 880_000;
    localparam int TONE_HZ = 22_000;
    localparam int HALF    = 20;
    localparam int P       = 2 * HALF;

    typedef struct {
        int    start;
        int    pulses;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, arm_bit = 1'b0, arm_pin = 1'b0, cont = 1'b0, key = 1'b0;
    logic tone, sink, ext;

    int   cyc = 0;
    int   n_chk = 0, n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tone22k_gate #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) i_tone22k_gate (
        .clk (clk), .rst_n (rst_n), .en_i (en), .arm_bit_i (arm_bit),
        .arm_pin_i (arm_pin), .cont_i (cont), .key_i (key),
        .tone_o (tone), .sink_o (sink), .ext_mod_o (ext)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int stop_pulses(input int j);
        int c;
        c = (j <= 0) ? 1 : (j + P - 1) / P;
        if (c < 1) c = 1;
        return c + 1;
    endfunction

    // Monitor: measures each run and compares it with the queued expectation.
    bit p_sink = 0, p_tone = 0;
    int run_start = 0, n_pul = 0, hl = 0, ll = 0, run_len = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tone && !sink) check("R9 tone while sink low", 1, 0);
            if (sink && !p_sink) begin
                run_start = cyc; n_pul = 0; hl = 0; ll = 0; run_len = 0;
            end
            if (sink) begin
                run_len++;
                if (tone && !p_tone) begin
                    if (n_pul > 0) check("R2 low half length", ll, HALF);
                    n_pul++; hl = 1;
                end else if (tone) begin
                    hl++;
                end else if (p_tone) begin
                    check("R2 high half length", hl, HALF);
                    ll = 1;
                end else begin
                    ll++;
                end
            end
            if (!sink && p_sink) begin
                if (q.size() == 0) begin
                    check("R6 unexpected run", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.tag, " run start edge"}, run_start, e.start);
                    if (e.pulses >= 0) begin
                        check({"R5 pulse count ", e.tag}, n_pul, e.pulses);
                        check({"R9 sink length ", e.tag}, run_len, e.pulses * P);
                        check({"R5 ends low ", e.tag}, p_tone, 0);
                    end
                end
            end
            p_sink = sink;
            p_tone = tone;
        end
    end

    // Driver: keyed burst of d cycles; queues the expected run.
    task automatic burst(input int d, input string tag, input bit probe);
        int k, e_start;
        exp_t e;
        @(negedge clk);
        k = cyc;
        key = 1'b1;
        e_start = k + 3 + HALF;
        e.start = e_start; e.pulses = stop_pulses(d - HALF); e.tag = tag;
        q.push_back(e);
        if (probe) begin
            repeat (HALF + 2) @(negedge clk);
            check("R4 still low before start", tone, 0);
            @(negedge clk);
            check("R4 high at start", tone, 1);
            repeat (d - HALF - 3) @(negedge clk);
        end else begin
            repeat (d) @(negedge clk);
        end
        key = 1'b0;
        repeat (6 * P) @(negedge clk);
    endtask

    task automatic quiet(input string req, input int len);
        bit seen = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 1) key = 1'b1;
            if (i == len - 2 * P) key = 1'b0;
            if (sink || tone) seen = 1;
        end
        check(req, seen, 0);
    endtask

    initial begin
        int k, e_start;
        exp_t e;
        repeat (3) @(negedge clk);
        check("R1 tone in reset", tone, 0);
        check("R1 sink in reset", sink, 0);
        check("R1 ext in reset", ext, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 ext after reset", ext, 0);

        // R7 external modulation select
        en = 1'b1;
        @(negedge clk);
        check("R7 ext when unarmed", ext, 1);
        cont = 1'b1;
        @(negedge clk);
        check("R7 ext off with cont", ext, 0);
        cont = 1'b0;
        arm_bit = 1'b1;
        @(negedge clk);
        check("R7 ext off when armed", ext, 0);

        // R3 continuous mode, stopped by clearing cont
        @(negedge clk);
        k = cyc;
        cont = 1'b1;
        @(negedge clk);
        check("R3 tone on first edge", tone, 1);
        check("R3 sink on first edge", sink, 1);
        repeat (3 * P + 4) @(negedge clk);
        k = k + 1;
        e.start = k; e.pulses = stop_pulses(cyc + 1 - k); e.tag = "R3";
        q.push_back(e);
        cont = 1'b0;
        repeat (6 * P) @(negedge clk);

        // R4/R5 bursts
        burst(5 * P + 7, "R4", 1'b1);
        burst(3, "R5 short", 1'b0);
        burst(P + HALF, "R5 boundary", 1'b1);
        burst(P + HALF + 1, "R5 past boundary", 1'b1);

        // R6 unarmed: keying and continuous ignored
        arm_bit = 1'b0;
        quiet("R6 key ignored unarmed", 5 * P);
        cont = 1'b1;
        quiet("R6 cont ignored unarmed", 3 * P);
        check("R7 ext off with cont unarmed", ext, 0);
        cont = 1'b0;
        @(negedge clk);
        check("R7 ext back on", ext, 1);

        // R6 arm pin path
        arm_pin = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 ext off via arm pin", ext, 0);
        burst(100, "R6 pin", 1'b0);
        arm_pin = 1'b0;
        arm_bit = 1'b1;
        repeat (4) @(negedge clk);

        // R8 enable drop mid high half
        @(negedge clk);
        e_start = cyc + 1;
        cont = 1'b1;
        repeat (HALF / 2) @(negedge clk);
        check("R8 tone high before disable", tone, 1);
        e.start = e_start; e.pulses = -1; e.tag = "R8";
        q.push_back(e);
        en = 1'b0;
        @(negedge clk);
        check("R8 tone forced off", tone, 0);
        check("R8 sink forced off", sink, 0);
        check("R8 ext off", ext, 0);
        repeat (2 * P) @(negedge clk);
        check("R8 stays off while disabled", sink, 0);
        cont = 1'b0;
        repeat (4) @(negedge clk);

        check("R5 all expected runs seen", q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule